// File: doc/BRIEF.md
# Peak-Current PWM Cycle Sequencer

This block is the digital cycle controller of a fixed-frequency, peak-current-mode flyback converter. A one-cycle tick from the oscillator starts every switching period and raises the gate request. The request falls when either the PWM comparator or the current-limit comparator reports a trip, but a trip is only acted on once a leading-edge blanking window has passed. If neither comparator trips, a maximum-duty guard ends the on-time at three quarters of the period. Once the gate is off, it stays off until the next tick. When the gate has been on for more than two fifths of the period, and the converter is not in burst operation, the block also asks for slope compensation.

A time-based soft start runs alongside the gate logic. It raises an 8-bit peak-limit code, in 10 mV units, that feeds an external DAC. The code climbs through four equal steps and then settles at the normal limit. At that point a jitter-enable flag is raised for the oscillator. A synchronous restart input sends the soft start back to its first step. Comparator results reach the block as synchronous single-bit signals, and all durations are counted in system-clock cycles.

Gate state machine:
- States: WAIT (gate off, off-event held), BLANK (gate on, trips masked) and CONDUCT (gate on, trips honoured).
- Transitions:
  - tick: any state to BLANK, or to CONDUCT when the blanking window is one cycle long.
  - window end: BLANK to CONDUCT.
  - trip: CONDUCT to WAIT.
  - max duty: BLANK or CONDUCT to WAIT.

Soft-start state machine:
- States: RAMP and DONE.
- Transitions:
  - last step elapsed: RAMP to DONE.
  - restart: any state to RAMP at step 0.

Top module: `pwm_cycle_seq`

## Requirements
- R1: A `period_tick` sampled high makes `gate_on` high in the next cycle, from any state. The on-time count then starts at 1.
- R2: A comparator trip sampled while fewer than `BLANK_CYC` on-cycles have elapsed is ignored. The gate therefore stays on for at least `BLANK_CYC` cycles.
- R3: Once the blanking window has elapsed, a trip on either `pwm_trip` or `ilim_trip` turns the gate off. If the trip is first driven in on-cycle k (k ≥ `BLANK_CYC`), the gate is high for exactly k cycles.
- R4: The gate is high for at most `PERIOD_CYC*3/4` cycles per period, whatever the comparators do.
- R5: After the gate turns off, it stays off until the next `period_tick`, even when the trips fall again.
- R6: `slope_en` is high exactly when `gate_on` is high, the current on-cycle number is greater than `PERIOD_CYC*2/5`, and `burst_active` is low.
- R7: `slope_en` is low in every cycle in which `burst_active` is high.
- R8: While soft start runs, `ilim_code` equals 30 + 15·s, where s (0..3) is the number of whole `STEP_CYC` blocks of enabled cycles since reset or restart. The code is in 10 mV units, so the levels are 0.30, 0.45, 0.60 and 0.75 V.
- R9: After 4·`STEP_CYC` enabled cycles, `ilim_code` is 80 (0.80 V) and `jitter_en` is high. Both then hold.
- R10: Cycles with `ss_enable` low do not advance the soft start; the code holds.
- R11: `ss_restart` sampled high returns the code to 30 and `jitter_en` to 0, whatever the value of `ss_enable`.
- R12: After reset, `gate_on`, `slope_en` and `jitter_en` are 0 and `ilim_code` is 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_tick | input | 1 | One-cycle pulse at the start of each switching period |
| pwm_trip | input | 1 | PWM comparator output (sensed current above feedback) |
| ilim_trip | input | 1 | Current-limit comparator output |
| burst_active | input | 1 | High while burst operation is in effect |
| ss_enable | input | 1 | Lets the soft-start timer advance |
| ss_restart | input | 1 | Synchronous return of soft start to its first step |
| gate_on | output | 1 | Gate-on request to the driver |
| slope_en | output | 1 | Slope-compensation enable |
| ilim_code | output | CODE_W | Peak-limit threshold code, 10 mV per LSB |
| jitter_en | output | 1 | Frequency-jitter enable, high once soft start has finished |

## Verification
The hardest situations to reach are the ones where a comparator trip lands exactly on an on-time boundary. These are the last masked cycle, the first honoured cycle, and the cycle where maximum duty forces the gate off anyway. A single trip pulse that arrives after the gate has already turned off is equally hard to reach. The stimulus reaches all of them by sweeping the trip-onset cycle over every position in the period, for a level trip on each comparator and for a single-cycle pulse, with burst off and on. For the soft start, a repeating enable pattern with gaps and a mid-ramp restart make the step edges fall at irregular times.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

    typedef enum logic [1:0] {
        G_WAIT    = 2'd0,
        G_BLANK   = 2'd1,
        G_CONDUCT = 2'd2
    } gate_st_t;

    typedef enum logic {
        S_RAMP = 1'b0,
        S_DONE = 1'b1
    } ss_st_t;

    // Threshold levels in 10 mV units
    localparam int unsigned LIM_START  = 30;
    localparam int unsigned LIM_STEP   = 15;
    localparam int unsigned LIM_NORMAL = 80;
    localparam int unsigned SS_STEPS   = 4;

endpackage

// File: rtl/pwm_gate_fsm.sv
module pwm_gate_fsm
    import pwm_seq_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 1000,
    parameter int unsigned BLANK_CYC  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_tick,
    input  logic pwm_trip,
    input  logic ilim_trip,
    input  logic burst_active,
    output logic gate_on,
    output logic slope_en
);
    localparam int unsigned TW       = $clog2(PERIOD_CYC + 1);
    localparam int unsigned MAX_ON   = PERIOD_CYC * 3 / 4;
    localparam int unsigned SLOPE_TH = PERIOD_CYC * 2 / 5;
    localparam logic [TW-1:0] MAX_V   = TW'(MAX_ON);
    localparam logic [TW-1:0] BLANK_V = TW'(BLANK_CYC);
    localparam logic [TW-1:0] SLOPE_V = TW'(SLOPE_TH);
    localparam logic [TW-1:0] ONE     = TW'(1);
    localparam gate_st_t FIRST_ST = (BLANK_CYC <= 1) ? G_CONDUCT : G_BLANK;

    gate_st_t st, st_n;
    logic [TW-1:0] ton, ton_n;
    logic trip;

    assign trip = pwm_trip | ilim_trip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= G_WAIT;
            ton <= '0;
        end else begin
            st  <= st_n;
            ton <= ton_n;
        end
    end

    always_comb begin
        st_n  = st;
        ton_n = ton;
        unique case (st)
            G_WAIT: begin
                if (period_tick) begin
                    st_n  = FIRST_ST;
                    ton_n = ONE;
                end
            end
            G_BLANK: begin
                if (period_tick) begin
                    st_n  = FIRST_ST;
                    ton_n = ONE;
                end else if (ton == MAX_V) begin
                    st_n  = G_WAIT;
                    ton_n = '0;
                end else begin
                    ton_n = ton + ONE;
                    st_n  = (ton_n >= BLANK_V) ? G_CONDUCT : G_BLANK;
                end
            end
            G_CONDUCT: begin
                if (period_tick) begin
                    st_n  = FIRST_ST;
                    ton_n = ONE;
                end else if (trip || ton == MAX_V) begin
                    st_n  = G_WAIT;
                    ton_n = '0;
                end else begin
                    ton_n = ton + ONE;
                end
            end
            default: begin
                st_n  = G_WAIT;
                ton_n = '0;
            end
        endcase
    end

    always_comb begin
        gate_on  = (st != G_WAIT);
        slope_en = gate_on && (ton > SLOPE_V) && !burst_active;
    end

    AST_TICK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> (gate_on && ton == ONE)); // R1
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !period_tick && ton < BLANK_V && ton < MAX_V) |=> gate_on); // R2
    AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == G_CONDUCT && trip && !period_tick) |=> !gate_on); // R3
    AST_MAX_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !period_tick && ton == MAX_V) |=> !gate_on); // R4
    AST_OFF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_on && !period_tick) |=> !gate_on); // R5

endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart
    import pwm_seq_pkg::*;
#(
    parameter int unsigned STEP_CYC = 300000,
    parameter int unsigned CODE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_enable,
    input  logic              ss_restart,
    output logic [CODE_W-1:0] ilim_code,
    output logic              jitter_en
);
    localparam int unsigned MW = $clog2(STEP_CYC);
    localparam int unsigned SW = $clog2(SS_STEPS);
    localparam logic [MW-1:0] TMR_LAST  = MW'(STEP_CYC - 1);
    localparam logic [SW-1:0] STEP_LAST = SW'(SS_STEPS - 1);
    localparam logic [CODE_W-1:0] CODE_FIRST = CODE_W'(LIM_START);

    ss_st_t st, st_n;
    logic [SW-1:0] step, step_n;
    logic [MW-1:0] tmr, tmr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_RAMP;
            step <= '0;
            tmr  <= '0;
        end else begin
            st   <= st_n;
            step <= step_n;
            tmr  <= tmr_n;
        end
    end

    always_comb begin
        st_n   = st;
        step_n = step;
        tmr_n  = tmr;
        if (ss_restart) begin
            st_n   = S_RAMP;
            step_n = '0;
            tmr_n  = '0;
        end else begin
            unique case (st)
                S_RAMP: begin
                    if (ss_enable) begin
                        if (tmr == TMR_LAST) begin
                            tmr_n = '0;
                            if (step == STEP_LAST) st_n = S_DONE;
                            else                   step_n = step + SW'(1);
                        end else begin
                            tmr_n = tmr + MW'(1);
                        end
                    end
                end
                S_DONE: begin
                    tmr_n = '0;
                end
                default: st_n = S_RAMP;
            endcase
        end
    end

    always_comb begin
        jitter_en = (st == S_DONE);
        if (st == S_DONE) ilim_code = CODE_W'(LIM_NORMAL);
        else              ilim_code = CODE_W'(LIM_START + LIM_STEP * int'(step));
    end

    AST_CODE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_restart |=> (ilim_code >= $past(ilim_code))); // R8
    AST_DONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        jitter_en |-> (ilim_code == CODE_W'(LIM_NORMAL))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_enable && !ss_restart) |=> $stable(ilim_code)); // R10
    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |=> (ilim_code == CODE_FIRST && !jitter_en)); // R11

endmodule

// File: rtl/pwm_cycle_seq.sv
module pwm_cycle_seq
    import pwm_seq_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 1000,
    parameter int unsigned BLANK_CYC  = 30,
    parameter int unsigned STEP_CYC   = 300000,
    parameter int unsigned CODE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_tick,
    input  logic              pwm_trip,
    input  logic              ilim_trip,
    input  logic              burst_active,
    input  logic              ss_enable,
    input  logic              ss_restart,
    output logic              gate_on,
    output logic              slope_en,
    output logic [CODE_W-1:0] ilim_code,
    output logic              jitter_en
);

    pwm_gate_fsm #(
        .PERIOD_CYC (PERIOD_CYC),
        .BLANK_CYC  (BLANK_CYC)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_tick  (period_tick),
        .pwm_trip     (pwm_trip),
        .ilim_trip    (ilim_trip),
        .burst_active (burst_active),
        .gate_on      (gate_on),
        .slope_en     (slope_en)
    );

    pwm_softstart #(
        .STEP_CYC (STEP_CYC),
        .CODE_W   (CODE_W)
    ) u_ss (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_enable  (ss_enable),
        .ss_restart (ss_restart),
        .ilim_code  (ilim_code),
        .jitter_en  (jitter_en)
    );

    AST_SLOPE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        slope_en |-> (gate_on && !burst_active)); // R7

endmodule

// File: tb/test_pwm_cycle_seq.sv
module test_pwm_cycle_seq;
    localparam int PER   = 20;
    localparam int LEB   = 3;
    localparam int STP   = 10;
    localparam int MAXON = PER * 3 / 4;
    localparam int SLTH  = PER * 2 / 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_tick = 1'b0, pwm_trip = 1'b0, ilim_trip = 1'b0, burst_active = 1'b0;
    logic ss_enable = 1'b0, ss_restart = 1'b0;
    logic gate_on, slope_en, jitter_en;
    logic [7:0] ilim_code;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    int ss_n = 0;

    always #4 clk = ~clk;

    pwm_cycle_seq #(
        .PERIOD_CYC (PER),
        .BLANK_CYC  (LEB),
        .STEP_CYC   (STP),
        .CODE_W     (8)
    ) i_pwm_cycle_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_tick  (period_tick),
        .pwm_trip     (pwm_trip),
        .ilim_trip    (ilim_trip),
        .burst_active (burst_active),
        .ss_enable    (ss_enable),
        .ss_restart   (ss_restart),
        .gate_on      (gate_on),
        .slope_en     (slope_en),
        .ilim_code    (ilim_code),
        .jitter_en    (jitter_en)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ss_expect(input int n);
        if (n >= 4 * STP) return 80;
        return 30 + 15 * (n / STP);
    endfunction

    // mode 0: level on pwm_trip, 1: level on ilim_trip, 2: one-cycle pulse on pwm_trip
    task automatic run_period(input int k, input int mode, input bit burst);
        int exp_on;
        if (mode == 2) exp_on = (k >= LEB && k <= MAXON) ? k : MAXON;
        else           exp_on = (k < LEB) ? LEB : ((k > MAXON) ? MAXON : k);
        for (int j = 0; j < PER; j++) begin
            @(negedge clk);
            if (j == 0) begin
                check("R5 gate idle before tick", int'(gate_on), 0);
            end else if (j == 1) begin
                check("R1 gate rises after tick", int'(gate_on), 1);
            end else begin
                string tag;
                if (j > exp_on)                   tag = "R5 latched off";
                else if (j <= LEB)                tag = "R2 blanking";
                else if (exp_on == MAXON && j == MAXON) tag = "R4 max duty";
                else                              tag = "R3 trip off";
                check(tag, int'(gate_on), int'(j <= exp_on));
            end
            check(burst ? "R7 slope in burst" : "R6 slope window", int'(slope_en),
                  int'(j >= 1 && j <= exp_on && j > SLTH && !burst));
            check("R10 code held while disabled", int'(ilim_code), 30);
            period_tick  = (j == PER - 1) ? 1'b0 : (j == 0);
            burst_active = burst;
            if (mode == 2) begin
                pwm_trip  = (j == k);
                ilim_trip = 1'b0;
            end else begin
                pwm_trip  = (mode == 0) && (j >= k);
                ilim_trip = (mode == 1) && (j >= k);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset gate", int'(gate_on), 0);
        check("R12 reset slope", int'(slope_en), 0);
        check("R12 reset code", int'(ilim_code), 30);
        check("R12 reset jitter", int'(jitter_en), 0);

        // Gate sweep: every trip onset, three trip styles, burst off and on
        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 3; m++)
                for (int k = 0; k < PER; k++)
                    run_period(k, m, b[0]);

        // Soft-start sweep with a gapped enable pattern and a mid-ramp restart
        @(negedge clk);
        period_tick = 1'b0; pwm_trip = 1'b0; ilim_trip = 1'b0; burst_active = 1'b0;
        ss_n = 0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            check(ss_n >= 4 * STP ? "R9 final code" : "R8 step code", int'(ilim_code), ss_expect(ss_n));
            check("R9 jitter flag", int'(jitter_en), int'(ss_n >= 4 * STP));
            ss_enable  = (c % 4 != 3);
            ss_restart = (c == 25);
            if (ss_restart)     ss_n = 0;
            else if (ss_enable) ss_n = ss_n + 1;
        end
        // Hold while disabled after completion, then restart with enable low
        ss_enable = 1'b0; ss_restart = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 hold after done", int'(ilim_code), 80);
        ss_restart = 1'b1;
        @(negedge clk);
        ss_restart = 1'b0;
        check("R11 restart code", int'(ilim_code), 30);
        check("R11 restart jitter", int'(jitter_en), 0);
        repeat (2 * STP) @(negedge clk);
        check("R10 no advance while disabled", int'(ilim_code), 30);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule